// File: doc/BRIEF.md
# Multiplexed Serial I/Q Output Formatter

This block takes one output sample of baseband data from two receive channels, an in-phase and a quadrature word for each, and sends it bit-serially on a single data pin to the serial port of a signal processor. A one-cycle sample-valid strobe copies all four words into a holding register. The block then produces a divided serial clock, a frame sync that marks the start of each channel's I/Q pair, and the serial data. A data-ready line is active while a frame is on the wire.

The serial clock is the system clock divided by a programmable ratio. The ratio is latched when the sample is captured, so a change made during a frame takes effect on the next one. The serial clock, frame sync and ready outputs each have a polarity select that applies at once. A sample that arrives while a frame is still being sent is discarded and raises an overrun pulse. This tells the integrator that the serial clock is too slow for the output sample rate.

Top module: `iq_serial_mux`

## Requirements
- R1: While reset is held and after it is released, the serial clock rests at its inactive level (equal to `sckPol`), frame sync is inactive (equal to `fsPol`), `sdata` is 0, ready is inactive (equal to `rdyPol`) and `overrun` is 0.
- R2: A high `sampleValid` while no frame is in progress captures `chanAI`, `chanAQ`, `chanBI`, `chanBQ` and `divSel` at that clock edge, and a frame starts in the next cycle. Changes to these inputs during the frame do not alter it.
- R3: A frame is 97 serial clock periods, numbered 0 to 96. Period 0 is a lead slot with `sdata` 0. Periods 1 to 96 carry the 96 data bits on `sdata`, in word order channel A I, channel A Q, channel B I, channel B Q, each 24-bit word most significant bit first.
- R4: Frame sync is active for exactly periods 0 and 48. Period 48 carries the last bit of the channel A Q word, so sync is active during the serial clock before the first bit of each I word.
- R5: One serial clock period lasts N system clocks, with N = `divSel` + 1 and `divSel` = 0 treated as N = 2 (range 2 to 256). Within each period the clock is inactive for the first floor(N/2) system clocks and active for the rest. Data and sync change only at period starts.
- R6: Outside a frame the serial clock stays inactive, frame sync stays inactive and `sdata` is 0.
- R7: Ready is active in every cycle of a frame, from the cycle after capture through the last system clock of period 96, and inactive otherwise.
- R8: A high `sampleValid` in any cycle of a frame, including its last cycle, makes `overrun` high in the following cycle. That sample is discarded and the frame in progress continues unchanged.
- R9: `sckPol`, `fsPol` and `rdyPol` invert the serial clock, frame sync and ready outputs respectively (1 = inverted), and take effect in the same cycle. `sdata` is never inverted.
- R10: A sample presented in the first cycle after a frame ends is accepted, so frames can run back to back with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | One-cycle strobe: a new output sample is present |
| chanAI | input | 24 | Channel A in-phase word |
| chanAQ | input | 24 | Channel A quadrature word |
| chanBI | input | 24 | Channel B in-phase word |
| chanBQ | input | 24 | Channel B quadrature word |
| divSel | input | 8 | Serial clock divide select, ratio = divSel + 1 (0 acts as 1) |
| sckPol | input | 1 | Serial clock polarity, 1 = inverted |
| fsPol | input | 1 | Frame sync polarity, 1 = inverted |
| rdyPol | input | 1 | Ready polarity, 1 = inverted |
| sck | output | 1 | Serial clock |
| fs | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| ready | output | 1 | Frame in progress |
| overrun | output | 1 | Pulse: a sample arrived during a frame and was dropped |

## Verification
The critical coincidence is a new sample strobe that lands in the very last system clock of a frame. In that cycle the block is finishing the final data bit and would be free one edge later. The bench waits until its reference model has exactly one expected cycle left and raises `sampleValid` there. It expects an overrun pulse with no restart. It then holds the strobe one more cycle, into the first idle cycle, and expects a fresh frame carrying the new words. Each cycle's serial clock, sync, data, ready and overrun values are compared against a queue of expected values. The model builds this queue from the requirement text at each accepted capture.

// File: rtl/iqser_pkg.sv
package iqser_pkg;

  // Two channels, each an I and a Q word.
  localparam int NUM_WORDS = 4;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic capture;  // load holding register
    logic shift;    // advance to next data bit
    logic dataEn;   // a data slot is on the wire
  } ctrl_strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } ser_state_e;

endpackage

// File: rtl/iqser_ctrl.sv
module iqser_ctrl
  import iqser_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleValid,
  input  logic [DIV_W-1:0] divSel,
  output ctrl_strobe_t     strobes,
  output logic             busy,
  output logic             sckRaw,
  output logic             fsRaw,
  output logic             overrunPulse
);

  localparam int FRAME_BITS = NUM_WORDS * WORD_W;
  localparam int SLOT_LAST  = FRAME_BITS;          // lead slot + data slots
  localparam int SLOT_W     = $clog2(FRAME_BITS + 1);
  localparam int SYNC_B     = (NUM_WORDS / 2) * WORD_W;  // last bit of channel A Q
  localparam int RATIO_W    = DIV_W + 1;

  ser_state_e          stateQ;
  logic [SLOT_W-1:0]   slotQ;
  logic [DIV_W-1:0]    phaseQ;
  logic [RATIO_W-1:0]  ratioQ;
  logic [RATIO_W-1:0]  ratioNew;
  logic [RATIO_W-1:0]  phaseExt;
  logic                periodEnd;
  logic                lastSlot;
  logic                overrunQ;

  assign busy     = (stateQ == ST_SEND);
  assign phaseExt = {1'b0, phaseQ};

  // Divide ratio: divSel + 1, with zero promoted to the minimum of two.
  assign ratioNew = (divSel == '0) ? RATIO_W'(2)
                                   : RATIO_W'(divSel) + RATIO_W'(1);

  assign periodEnd = busy && (phaseExt == (ratioQ - RATIO_W'(1)));
  assign lastSlot  = (slotQ == SLOT_W'(SLOT_LAST));

  always_comb begin
    strobes         = '0;
    strobes.capture = sampleValid && !busy;
    strobes.shift   = periodEnd && (slotQ != '0);
    strobes.dataEn  = busy && (slotQ != '0);
  end

  // Clock low for the first half (rounded down) of every period.
  assign sckRaw = busy && (phaseExt >= (ratioQ >> 1));
  assign fsRaw  = busy && ((slotQ == '0) || (slotQ == SLOT_W'(SYNC_B)));

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ   <= ST_IDLE;
      slotQ    <= '0;
      phaseQ   <= '0;
      ratioQ   <= RATIO_W'(2);
      overrunQ <= 1'b0;
    end else begin
      overrunQ <= sampleValid && busy;
      case (stateQ)
        ST_IDLE: begin
          if (sampleValid) begin
            stateQ <= ST_SEND;
            slotQ  <= '0;
            phaseQ <= '0;
            ratioQ <= ratioNew;
          end
        end
        ST_SEND: begin
          if (periodEnd) begin
            phaseQ <= '0;
            if (lastSlot) begin
              stateQ <= ST_IDLE;
            end else begin
              slotQ <= slotQ + 1'b1;
            end
          end else begin
            phaseQ <= phaseQ + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign overrunPulse = overrunQ;

endmodule

// File: rtl/iqser_datapath.sv
module iqser_datapath
  import iqser_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_strobe_t      strobes,
  input  logic [WORD_W-1:0] words [NUM_WORDS],
  input  logic              busy,
  input  logic              sckRaw,
  input  logic              fsRaw,
  input  logic              sckPol,
  input  logic              fsPol,
  input  logic              rdyPol,
  output logic              sck,
  output logic              fs,
  output logic              sdata,
  output logic              ready
);

  localparam int FRAME_BITS = NUM_WORDS * WORD_W;

  logic [FRAME_BITS-1:0] framePacked;
  logic [FRAME_BITS-1:0] holdQ;

  // Word 0 lands in the top bits so it leaves first.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_pack
    assign framePacked[FRAME_BITS-1-w*WORD_W -: WORD_W] = words[w];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdQ <= '0;
    end else if (strobes.capture) begin
      holdQ <= framePacked;
    end else if (strobes.shift) begin
      holdQ <= {holdQ[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign sdata = strobes.dataEn && holdQ[FRAME_BITS-1];
  assign sck   = sckRaw ^ sckPol;
  assign fs    = fsRaw ^ fsPol;
  assign ready = busy ^ rdyPol;

endmodule

// File: rtl/iq_serial_mux.sv
module iq_serial_mux
  import iqser_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleValid,
  input  logic [WORD_W-1:0] chanAI,
  input  logic [WORD_W-1:0] chanAQ,
  input  logic [WORD_W-1:0] chanBI,
  input  logic [WORD_W-1:0] chanBQ,
  input  logic [DIV_W-1:0]  divSel,
  input  logic              sckPol,
  input  logic              fsPol,
  input  logic              rdyPol,
  output logic              sck,
  output logic              fs,
  output logic              sdata,
  output logic              ready,
  output logic              overrun
);

  ctrl_strobe_t      strobes;
  logic              busy;
  logic              sckRaw;
  logic              fsRaw;
  logic [WORD_W-1:0] wordArr [NUM_WORDS];

  assign wordArr[0] = chanAI;
  assign wordArr[1] = chanAQ;
  assign wordArr[2] = chanBI;
  assign wordArr[3] = chanBQ;

  iqser_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .sampleValid  (sampleValid),
    .divSel       (divSel),
    .strobes      (strobes),
    .busy         (busy),
    .sckRaw       (sckRaw),
    .fsRaw        (fsRaw),
    .overrunPulse (overrun)
  );

  iqser_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .words   (wordArr),
    .busy    (busy),
    .sckRaw  (sckRaw),
    .fsRaw   (fsRaw),
    .sckPol  (sckPol),
    .fsPol   (fsPol),
    .rdyPol  (rdyPol),
    .sck     (sck),
    .fs      (fs),
    .sdata   (sdata),
    .ready   (ready)
  );

endmodule

// File: rtl/iqser_checker.sv
module iqser_checker #(
  parameter int WORD_W = 24,
  parameter int DIV_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sampleValid,
  input logic [WORD_W-1:0] chanAI,
  input logic [WORD_W-1:0] chanAQ,
  input logic [WORD_W-1:0] chanBI,
  input logic [WORD_W-1:0] chanBQ,
  input logic [DIV_W-1:0]  divSel,
  input logic              sckPol,
  input logic              fsPol,
  input logic              rdyPol,
  input logic              sck,
  input logic              fs,
  input logic              sdata,
  input logic              ready,
  input logic              overrun
);

  logic busyP;
  logic fsA;
  logic unusedIn;

  assign busyP    = ready ^ rdyPol;
  assign fsA      = fs ^ fsPol;
  assign unusedIn = ^{chanAI, chanAQ, chanBI, chanBQ, divSel};

  assert_sync_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
    fsA |-> busyP);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !busyP |-> (!sdata && (sck == sckPol) && !fsA));

  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(sampleValid && busyP));

  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && busyP) |=> overrun);

  assert_start_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busyP) |-> $past(sampleValid));

  assert_no_sync_at_end_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busyP) |-> $past(!fsA));

endmodule

bind iq_serial_mux iqser_checker #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_iqser_chk (.*);

// File: tb/test_iq_serial_mux.sv
`timescale 1ns/1ps
module test_iq_serial_mux;

  localparam int WORD_W = 24;
  localparam int DIV_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sampleValid = 1'b0;
  logic [WORD_W-1:0] chanAI = '0, chanAQ = '0, chanBI = '0, chanBQ = '0;
  logic [DIV_W-1:0]  divSel = 8'd1;
  logic              sckPol = 1'b0, fsPol = 1'b0, rdyPol = 1'b0;
  logic              sck, fs, sdata, ready, overrun;

  int    checks = 0;
  int    errors = 0;
  bit    chkOn  = 1'b0;
  string scen   = "R3";

  logic [2:0] expQ [$];   // {sck, fs, data} per system clock
  logic       expOvr = 1'b0;

  always #2 clk = ~clk;

  iq_serial_mux #(.WORD_W(WORD_W), .DIV_W(DIV_W)) i_iq_serial_mux (
    .clk(clk), .rst(rst), .sampleValid(sampleValid),
    .chanAI(chanAI), .chanAQ(chanAQ), .chanBI(chanBI), .chanBQ(chanBQ),
    .divSel(divSel), .sckPol(sckPol), .fsPol(fsPol), .rdyPol(rdyPol),
    .sck(sck), .fs(fs), .sdata(sdata), .ready(ready), .overrun(overrun));

  task automatic cmp(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] %s: actual %0b expected %0b at %0t", tag, scen, what, act, exp, $time);
    end
  endtask

  // Build the expected frame from R3, R4, R5.
  task automatic buildFrame();
    int ratio;
    logic [WORD_W-1:0] w [4];
    ratio = (divSel == 0) ? 2 : int'(divSel) + 1;
    w[0] = chanAI; w[1] = chanAQ; w[2] = chanBI; w[3] = chanBQ;
    for (int s = 0; s <= 96; s++) begin
      logic f, d;
      f = (s == 0) || (s == 48);
      if (s == 0) d = 1'b0;
      else d = w[(s-1)/WORD_W][WORD_W-1-((s-1)%WORD_W)];
      for (int c = 0; c < ratio; c++) begin
        logic k;
        k = (c >= ratio/2);
        expQ.push_back({k, f, d});
      end
    end
  endtask

  // Reference model update at each edge.
  always @(posedge clk) begin
    if (rst) begin
      expQ.delete();
      expOvr = 1'b0;
    end else begin
      bit busyPrev;
      busyPrev = (expQ.size() != 0);
      if (busyPrev) void'(expQ.pop_front());
      expOvr = sampleValid && busyPrev;
      if (sampleValid && !busyPrev) buildFrame();
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (chkOn) begin
      logic [2:0] e;
      logic       b;
      string      t;
      b = (expQ.size() != 0);
      e = b ? expQ[0] : 3'b000;
      t = b ? "R5" : "R6";
      cmp(t, "sck", sck, e[2] ^ sckPol);
      cmp(b ? "R4" : "R6", "fs", fs, e[1] ^ fsPol);
      cmp(b ? "R3" : "R6", "sdata", sdata, e[0]);
      cmp("R7", "ready", ready, b ^ rdyPol);
      cmp("R8", "overrun", overrun, expOvr);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic loadWords();
    chanAI = WORD_W'($urandom); chanAQ = WORD_W'($urandom);
    chanBI = WORD_W'($urandom); chanBQ = WORD_W'($urandom);
  endtask

  task automatic sendSample();
    loadWords();
    sampleValid = 1'b1;
    step();
    sampleValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (expQ.size() != 0) step();
    repeat (3) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R1: reset values
    scen = "R1";
    cmp("R1", "sck", sck, sckPol);
    cmp("R1", "fs", fs, fsPol);
    cmp("R1", "sdata", sdata, 1'b0);
    cmp("R1", "ready", ready, rdyPol);
    cmp("R1", "overrun", overrun, 1'b0);
    rst = 1'b0;
    step();
    chkOn = 1'b1;

    // R3: basic frame, ratio 2, fixed patterns
    scen = "R3"; divSel = 8'd1;
    chanAI = 24'hA5F00F; chanAQ = 24'h800001; chanBI = 24'h7FFFFE; chanBQ = 24'h13579B;
    sampleValid = 1'b1; step(); sampleValid = 1'b0;
    waitIdle();

    // R5: odd ratio 3, then divSel 0 acting as ratio 2
    scen = "R5"; divSel = 8'd2; sendSample(); waitIdle();
    divSel = 8'd0; sendSample(); waitIdle();

    // R9: all polarities inverted, ratio 5, polarity flips mid-frame
    scen = "R9"; sckPol = 1'b1; fsPol = 1'b1; rdyPol = 1'b1; divSel = 8'd4;
    sendSample();
    repeat (30) step();
    fsPol = 1'b0;
    repeat (40) step();
    sckPol = 1'b0; fsPol = 1'b1;
    waitIdle();
    sckPol = 1'b0; fsPol = 1'b0; rdyPol = 1'b0;
    repeat (2) step();

    // R2: inputs and divider scrambled during the frame
    scen = "R2"; divSel = 8'd3; sendSample();
    for (int i = 0; i < 200; i++) begin
      loadWords(); divSel = DIV_W'($urandom); step();
    end
    divSel = 8'd3;
    waitIdle();

    // R8: sample mid-frame is dropped
    scen = "R8"; divSel = 8'd2; sendSample();
    repeat (50) step();
    sendSample();
    repeat (20) step();
    sendSample();
    waitIdle();

    // R8 and R10: strobe in the last frame cycle, then in the first idle cycle
    scen = "R10"; divSel = 8'd1; sendSample();
    while (expQ.size() > 1) step();
    loadWords(); sampleValid = 1'b1;
    step();                     // overrun expected from this edge
    loadWords();                // first idle cycle: accepted
    step();
    sampleValid = 1'b0;
    waitIdle();

    // R5: widest ratio 256
    scen = "R5"; divSel = 8'd255; sendSample(); waitIdle();

    chkOn = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule